// File: doc/BRIEF.md
# QAM Symbol Packer and Frame Synchronizer

This block sits between a QAM demapper and the de-interleaver of a cable receiver. It takes demapped symbols, one per cycle when a valid strobe is high. A mode input selects 16, 64 or 256 QAM. The block packs the symbol bits into bytes and then looks for transport packet alignment in the byte stream. Packets are 204 bytes long. Each packet starts with a marker byte of 0x47, and one marker in eight is sent bit-inverted as 0xB8.

A hunt/lock state machine confirms alignment before any data moves on. In hunt it requires a programmable number of consecutive markers at the right spacing. Once locked it tolerates up to a programmable number of consecutive missing markers. While locked, every byte is forwarded with a lock flag, and a start-of-packet pulse marks each correctly placed marker. Nothing is forwarded in hunt.

Top module: `qam_frame_sync`

## Requirements
- R1: In 16 QAM (`mode` = 0) each symbol supplies `sym[3:0]`, and two symbols make one byte. The first symbol fills bits 7:4.
- R2: In 64 QAM (`mode` = 1) each symbol supplies `sym[5:0]`, and four symbols make three bytes. Bits are taken most significant first across symbol boundaries.
- R3: In 256 QAM (`mode` = 2, and also `mode` = 3) each symbol `sym[7:0]` is one byte, produced on the cycle after the symbol.
- R4: A change of `mode` between cycles discards any partially packed bits. The first symbol in the new mode starts a fresh byte.
- R5: In hunt, a byte of 0x47 or 0xB8 opens a trial alignment. Lock is declared when `hit_thr` consecutive markers have been seen 204 bytes apart (`hit_thr` of 0 acts as 1). The marker that completes lock is forwarded with `out_sop`.
- R6: During a trial, a non-marker byte at the expected marker position ends the trial and clears the hit count.
- R7: No byte is forwarded (`out_valid` low) while the block is not locked.
- R8: While locked, a non-marker byte at an expected marker position counts a miss. When `miss_thr` consecutive misses are reached (`miss_thr` of 0 acts as 1), the block returns to hunt, and that byte is not forwarded. Earlier missed bytes are still forwarded.
- R9: While locked, a marker at the expected position clears the miss count.
- R10: `out_sop` is high exactly for forwarded bytes that sit at an expected marker position and hold 0x47 or 0xB8. It is never high without `out_valid`.
- R11: After reset the block is in hunt, with `locked`, `out_valid` and `out_sop` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Constellation: 0 = 16 QAM, 1 = 64 QAM, 2/3 = 256 QAM |
| sym | input | 8 | Demapped symbol, right-aligned |
| sym_valid | input | 1 | Symbol strobe |
| hit_thr | input | 4 | Consecutive markers needed to lock |
| miss_thr | input | 4 | Consecutive misses needed to drop lock |
| out_byte | output | 8 | Forwarded byte |
| out_valid | output | 1 | Forwarded byte strobe |
| out_sop | output | 1 | Start-of-packet marker |
| locked | output | 1 | Lock flag |

## Verification
The bench uses the default packet length of 204 bytes and 4-bit thresholds. It sets the thresholds between 1 and 3 per scenario, so every lock and unlock decision happens within a few packets. Each scenario builds a byte stream with chosen markers corrupted, then serializes it into symbols MSB-first in the mode under test, with idle gaps between symbols. The forwarded window and the positions of the start pulses follow arithmetically from the packet index where lock completes or drops. Short junk symbols sent in a different mode before a stream expose any carry-over of packed bits.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
  localparam logic [7:0] MARK_TRUE = 8'h47;
  localparam logic [7:0] MARK_INV  = 8'hB8;

  typedef enum logic {ST_HUNT, ST_LOCK} sync_state_t;

  // Bits carried per symbol for a given mode code.
  function automatic logic [3:0] sym_bits(input logic [1:0] m);
    case (m)
      2'd0:    sym_bits = 4'd4;
      2'd1:    sym_bits = 4'd6;
      default: sym_bits = 4'd8;
    endcase
  endfunction

  function automatic logic is_marker(input logic [7:0] b);
    is_marker = (b == MARK_TRUE) || (b == MARK_INV);
  endfunction

  // Threshold of zero behaves as one.
  function automatic logic [4:0] eff_thr(input logic [3:0] t);
    eff_thr = (t == 4'd0) ? 5'd1 : {1'b0, t};
  endfunction
endpackage

// File: rtl/qfs_packer.sv
module qfs_packer
  import qfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [7:0] sym,
  input  logic       sym_valid,
  output logic [7:0] pk_byte,
  output logic       pk_valid
);
  logic [15:0] acc_q;
  logic [3:0]  cnt_q;
  logic [1:0]  mode_q;
  logic        mode_chg;
  logic [3:0]  nb, base_cnt, tot;
  logic [15:0] sym_m, cat;

  always_comb begin
    mode_chg = (mode != mode_q);
    nb       = sym_bits(mode);
    base_cnt = mode_chg ? 4'd0 : cnt_q;
    tot      = base_cnt + nb;
    sym_m    = {8'd0, sym} & ((16'd1 << nb) - 16'd1);
    cat      = (acc_q << nb) | sym_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      mode_q   <= 2'd2;
      pk_valid <= 1'b0;
      pk_byte  <= '0;
    end else begin
      mode_q   <= mode;
      pk_valid <= 1'b0;
      if (sym_valid) begin
        acc_q <= cat;
        if (tot >= 4'd8) begin
          pk_valid <= 1'b1;
          pk_byte  <= 8'(cat >> (tot - 4'd8));
          cnt_q    <= tot - 4'd8;
        end else begin
          cnt_q <= tot;
        end
      end else if (mode_chg) begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/qfs_sync_fsm.sv
module qfs_sync_fsm
  import qfs_pkg::*;
#(
  parameter int PKT_LEN = 204,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_byte,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] hit_thr,
  input  logic [CNT_W-1:0] miss_thr,
  output logic [7:0]       out_byte,
  output logic             out_valid,
  output logic             out_sop,
  output logic             locked,
  output logic             evt_hit,
  output logic             evt_miss
);
  localparam int POS_W = $clog2(PKT_LEN);
  localparam logic [POS_W-1:0] LAST = POS_W'(PKT_LEN - 1);

  sync_state_t      st_q, st_d;
  logic [CNT_W-1:0] hit_q, hit_d, miss_q, miss_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             mk, at_exp, fwd, sop;
  logic [CNT_W:0]   h_thr, m_thr;

  always_comb begin
    h_thr = CNT_W'(0) + eff_thr(hit_thr[3:0]);
    m_thr = CNT_W'(0) + eff_thr(miss_thr[3:0]);
  end

  always_comb begin
    mk       = is_marker(in_byte);
    at_exp   = (pos_q == LAST);
    st_d     = st_q;
    hit_d    = hit_q;
    miss_d   = miss_q;
    pos_d    = pos_q;
    fwd      = 1'b0;
    sop      = 1'b0;
    evt_hit  = 1'b0;
    evt_miss = 1'b0;
    if (in_valid) begin
      pos_d = at_exp ? '0 : pos_q + 1'b1;
      if (st_q == ST_HUNT) begin
        if (hit_q == '0) begin
          if (mk) begin
            pos_d   = '0;
            evt_hit = 1'b1;
            if (h_thr <= 1) begin
              st_d = ST_LOCK; miss_d = '0; fwd = 1'b1; sop = 1'b1;
            end else begin
              hit_d = CNT_W'(1);
            end
          end
        end else if (at_exp) begin
          if (mk) begin
            evt_hit = 1'b1;
            if ({1'b0, hit_q} + 1'b1 >= h_thr) begin
              st_d = ST_LOCK; hit_d = '0; miss_d = '0; fwd = 1'b1; sop = 1'b1;
            end else begin
              hit_d = hit_q + 1'b1;
            end
          end else begin
            hit_d = '0;
          end
        end
      end else begin
        fwd = 1'b1;
        if (at_exp) begin
          if (mk) begin
            miss_d = '0;
            sop    = 1'b1;
          end else begin
            evt_miss = 1'b1;
            if ({1'b0, miss_q} + 1'b1 >= m_thr) begin
              st_d = ST_HUNT; hit_d = '0; fwd = 1'b0;
            end else begin
              miss_d = miss_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_HUNT;
      hit_q     <= '0;
      miss_q    <= '0;
      pos_q     <= '0;
      out_byte  <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
    end else begin
      st_q      <= st_d;
      hit_q     <= hit_d;
      miss_q    <= miss_d;
      pos_q     <= pos_d;
      out_valid <= fwd;
      out_sop   <= sop;
      if (fwd) out_byte <= in_byte;
    end
  end

  assign locked = (st_q == ST_LOCK);
endmodule

// File: rtl/qam_frame_sync.sv
module qam_frame_sync
  import qfs_pkg::*;
#(
  parameter int PKT_LEN = 204,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [7:0]       sym,
  input  logic             sym_valid,
  input  logic [CNT_W-1:0] hit_thr,
  input  logic [CNT_W-1:0] miss_thr,
  output logic [7:0]       out_byte,
  output logic             out_valid,
  output logic             out_sop,
  output logic             locked
);
  logic [7:0] pk_byte;
  logic       pk_valid;
  logic       evt_hit, evt_miss;

  qfs_packer u_pack (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sym(sym), .sym_valid(sym_valid),
    .pk_byte(pk_byte), .pk_valid(pk_valid)
  );

  qfs_sync_fsm #(.PKT_LEN(PKT_LEN), .CNT_W(CNT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .in_byte(pk_byte), .in_valid(pk_valid),
    .hit_thr(hit_thr), .miss_thr(miss_thr),
    .out_byte(out_byte), .out_valid(out_valid), .out_sop(out_sop),
    .locked(locked), .evt_hit(evt_hit), .evt_miss(evt_miss)
  );
endmodule

// File: rtl/qfs_checker.sv
module qfs_checker
  import qfs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       sym_valid,
  input logic       pk_valid,
  input logic       evt_hit,
  input logic       evt_miss,
  input logic [7:0] out_byte,
  input logic       out_valid,
  input logic       out_sop,
  input logic       locked
);
  // R3
  full_symbol_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && mode[1]) |=> pk_valid);
  // R7
  forward_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> locked);
  // R10
  sop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
  // R10
  sop_holds_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> is_marker(out_byte));
  // R5
  lock_starts_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> out_sop);
  // R8
  unlock_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !out_valid);
  // R8
  hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_hit && evt_miss));
endmodule

bind qam_frame_sync qfs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sym_valid(sym_valid),
  .pk_valid(pk_valid), .evt_hit(evt_hit), .evt_miss(evt_miss),
  .out_byte(out_byte), .out_valid(out_valid), .out_sop(out_sop), .locked(locked)
);

// File: tb/sim_qam_frame_sync.sv
module sim_qam_frame_sync;
  localparam int CLK_PER = 10;
  localparam int PL      = 204;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd2;
  logic [7:0] sym = '0;
  logic       sym_valid = 1'b0;
  logic [3:0] hit_thr = 4'd1, miss_thr = 4'd1;
  logic [7:0] out_byte;
  logic       out_valid, out_sop, locked;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] strm [0:2047];
  int slen;
  logic [8:0] got [$];

  always #(CLK_PER/2) clk = ~clk;

  qam_frame_sync u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sym(sym), .sym_valid(sym_valid),
    .hit_thr(hit_thr), .miss_thr(miss_thr),
    .out_byte(out_byte), .out_valid(out_valid), .out_sop(out_sop), .locked(locked)
  );

  always @(negedge clk) if (rst_n && out_valid) got.push_back({out_sop, out_byte});

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit mk(input logic [7:0] b);
    return (b == 8'h47) || (b == 8'hB8);
  endfunction

  task automatic build(input int pre, input int npk, input int bad0, input int bad1);
    slen = pre + npk * PL;
    for (int i = 0; i < slen; i++) strm[i] = 8'((i * 5 + 3) % 64);
    for (int p = 0; p < npk; p++) begin
      if (p == bad0 || p == bad1) strm[pre + p*PL] = 8'h00;
      else strm[pre + p*PL] = (p % 8 == 2) ? 8'hB8 : 8'h47;
    end
  endtask

  task automatic send_stream(input logic [1:0] m);
    int nb = (m == 2'd0) ? 4 : (m == 2'd1) ? 6 : 8;
    int nsym = slen * 8 / nb;
    for (int s = 0; s < nsym; s++) begin
      logic [7:0] sv = '0;
      for (int b = 0; b < nb; b++) begin
        int bi = s * nb + b;
        sv = {sv[6:0], strm[bi / 8][7 - (bi % 8)]};
      end
      @(negedge clk); mode = m; sym = sv; sym_valid = 1'b1;
      if (s % 5 == 4) begin @(negedge clk); sym_valid = 1'b0; end
    end
    @(negedge clk); sym_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; sym_valid = 1'b0;
    repeat (2) @(negedge clk);
    got.delete();
    rst_n = 1'b1;
  endtask

  task automatic run(input string req, input logic [1:0] m, input int h, input int mt,
                     input int pre, input int npk, input int bad0, input int bad1,
                     input int s, input int e, input bit exp_lock,
                     input logic [1:0] jm, input int jn);
    int bad_d = 0, bad_s = 0, fd = -1;
    build(pre, npk, bad0, bad1);
    hit_thr = 4'(h); miss_thr = 4'(mt);
    do_reset();
    for (int j = 0; j < jn; j++) begin
      @(negedge clk); mode = jm; sym = 8'h2D; sym_valid = 1'b1;
    end
    send_stream(m);
    repeat (6) @(negedge clk);
    check({req, " forwarded count"}, got.size() == e - s, got.size(), e - s);
    for (int i = 0; i < got.size() && i < e - s; i++) begin
      int idx = s + i;
      bit xs = (idx >= pre) && ((idx - pre) % PL == 0) && mk(strm[idx]);
      if (got[i][7:0] != strm[idx]) begin bad_d++; if (fd < 0) fd = i; end
      if (got[i][8] != xs) bad_s++;
    end
    check({req, " forwarded data mismatches"}, bad_d == 0, bad_d, 0);
    check({req, " R10 sop mismatches"}, bad_s == 0, bad_s, 0);
    check({req, " final lock"}, locked == exp_lock, int'(locked), int'(exp_lock));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R11 locked after reset", locked == 1'b0, int'(locked), 0);
    check("R11 out_valid after reset", out_valid == 1'b0, int'(out_valid), 0);
    check("R11 out_sop after reset", out_sop == 1'b0, int'(out_sop), 0);
    // R3 R5 R7: preamble, three markers to lock, inverted marker accepted
    run("R5 R3", 2'd2, 3, 2, 10, 5, -1, -1, 10 + 2*PL, 10 + 5*PL, 1'b1, 2'd2, 0);
    // R8: two consecutive misses drop lock, second not forwarded
    run("R8", 2'd2, 3, 2, 0, 8, 5, 6, 2*PL, 6*PL, 1'b0, 2'd2, 0);
    // R9: alternating misses never reach threshold of two
    run("R9", 2'd2, 1, 2, 0, 6, 1, 3, 0, 6*PL, 1'b1, 2'd2, 0);
    // R6: mismatch during trial clears hit count
    run("R6", 2'd2, 2, 1, 0, 5, 1, -1, 3*PL, 5*PL, 1'b1, 2'd2, 0);
    // R8 R7: single-miss threshold
    run("R8 R7", 2'd2, 2, 1, 0, 4, 2, -1, PL, 2*PL, 1'b0, 2'd2, 0);
    // R1: 16 QAM packing
    run("R1", 2'd0, 1, 2, 0, 2, -1, -1, 0, 2*PL, 1'b1, 2'd2, 0);
    // R2: 64 QAM packing
    run("R2", 2'd1, 1, 2, 0, 2, -1, -1, 0, 2*PL, 1'b1, 2'd2, 0);
    // R4: dangling 16 QAM nibble then 256 QAM stream
    run("R4 16to256", 2'd2, 1, 2, 0, 2, -1, -1, 0, 2*PL, 1'b1, 2'd0, 1);
    // R4: dangling 64 QAM symbol then 16 QAM stream
    run("R4 64to16", 2'd0, 1, 2, 0, 2, -1, -1, 0, 2*PL, 1'b1, 2'd1, 1);
    // R2 R4: three dangling 16 QAM nibbles then 64 QAM stream, threshold zero acts as one
    run("R2 R4 thr0", 2'd1, 0, 0, 0, 3, -1, -1, 0, 3*PL, 1'b1, 2'd0, 3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule